// File: doc/BRIEF.md
# PCM Time Slot Interchange Core

This block is a memory-based time switch for serial PCM. Every input line carries a frame of `SLOTS` eight-bit channels. The channels are sent MSB first, one bit per device clock. Each received channel is written into a fixed position of a data store, and that position is `line*SLOTS + slot`. The same byte goes into two identical copies of the store at the same time. The output lines are split into a lower half and an upper half. Each half reads its own copy of the store through its own table of connection entries. An entry names the stored channel that is sent in one output time slot, and it carries a high-impedance bit that silences that slot.

A frame-position counter is shared by the input and output sides. It free-runs and is realigned by a rising edge on the sync input, which is sampled on the falling clock edge. The output frame is aligned with the input frame. A simple host port writes connection entries one at a time. A clear command walks through every entry, one per clock, and marks each one high-impedance. While the walk runs, the busy flag is high and host writes are dropped. At the end, a one-cycle done pulse is given. A per-line enable mask silences whole output lines. The channel and line counts are parameters (powers of two), kept small by default.

Top module: `tsi_core`

## Requirements
- R1: After reset, clr_busy and clr_done are low, pcm_oe is all zero, and every connection entry is high-impedance until it is written.
- R2: The output byte for line k, slot s comes from the entry at host address `k*SLOTS + s`. Its cm_src value `i*SLOTS + j` selects the byte received on input line i in slot j. The byte is sent MSB first, and bit b of slot s appears during frame position `8*s + (7-b)`.
- R3: Lines below OUT_LINES/2 and lines at or above it use separate entry tables, which are addressed by the top bit of cm_addr. Both halves can send the same input channel in the same slot.
- R4: A slot whose entry has the high-impedance bit set drives pcm_oe low and pcm_out low for all eight bits.
- R5: When line_en[k] is low, pcm_oe[k] and pcm_out[k] stay low whatever the entries hold.
- R6: A rising fsync that is first seen at a falling clock edge makes the next rising edge take frame position 0. A sync held high does not realign again.
- R7: A clr_start pulse while idle raises clr_busy on the next cycle. clr_busy stays high for exactly OUT_LINES/2*SLOTS cycles. It falls together with a one-cycle clr_done pulse, and after that every slot is high-impedance.
- R8: A host write issued while clr_busy is high has no effect.
- R9: A clr_start while clr_busy is high is ignored, so the walk length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, one PCM bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, rising edge realigns (falling-edge sampled) |
| pcm_in | input | IN_LINES | Serial PCM input lines |
| line_en | input | OUT_LINES | Per-line output enable mask |
| cm_we | input | 1 | Host connection-entry write strobe |
| cm_addr | input | log2(OUT_LINES*SLOTS) | Entry address, `out_line*SLOTS + slot` |
| cm_src | input | log2(IN_LINES*SLOTS) | Source channel, `in_line*SLOTS + slot` |
| cm_hiz | input | 1 | High-impedance bit for the written entry |
| clr_start | input | 1 | Start the clear-to-high-impedance walk |
| pcm_out | output | OUT_LINES | Serial PCM output lines (low when not enabled) |
| pcm_oe | output | OUT_LINES | Per-line, per-slot output enable |
| clr_busy | output | 1 | Clear walk in progress |
| clr_done | output | 1 | One-cycle pulse when the walk finishes |

## Verification
The assertions check on every cycle that the clear walk has the right length and that the done pulse follows it. They also check that an idle start raises busy, that no line drives data while its enable is low, and that the outputs hold their reset values. Only the bench's scenarios can show the data path: that a byte arriving on a given line and slot reaches the chosen output slot, MSB first and in the right position. The same holds for the entries being shared correctly between the two halves, for realignment after a sync at an arbitrary phase, and for host writes and repeated starts having no effect while the walk is running.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int CHAN_BITS = 8;

    typedef logic [CHAN_BITS-1:0] pcm_byte_t;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

endpackage

// File: rtl/tsi_frame_timer.sv
// Shared frame-position counter; sync edge detected from a falling-edge sample.
module tsi_frame_timer #(
    parameter int SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fsync,
    output logic [$clog2(SLOTS)-1:0]   slot,
    output logic [$clog2(SLOTS)-1:0]   next_slot,
    output logic                       bit_last
);
    localparam int SW         = $clog2(SLOTS);
    localparam int PW         = SW + 3;
    localparam int FRAME_BITS = SLOTS * tsi_pkg::CHAN_BITS;

    typedef struct packed {
        logic [PW-1:0] pos;
        logic          sync_prev;
    } timer_t;

    timer_t   tm_d, tm_q;
    logic     sync_fall_q;
    logic [PW-1:0] pos_now;

    // fsync is sampled on the falling edge of the device clock
    always_ff @(negedge clk) begin
        if (rst) sync_fall_q <= 1'b0;
        else     sync_fall_q <= fsync;
    end

    always_comb begin
        tm_d           = tm_q;
        tm_d.sync_prev = sync_fall_q;
        pos_now        = (sync_fall_q && !tm_q.sync_prev) ? '0 : tm_q.pos;
        tm_d.pos       = (pos_now == PW'(FRAME_BITS - 1)) ? '0 : pos_now + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    assign slot      = pos_now[PW-1:3];
    assign bit_last  = (pos_now[2:0] == 3'd7);
    assign next_slot = (slot == SW'(SLOTS - 1)) ? '0 : slot + SW'(1);

endmodule

// File: rtl/tsi_rx_capture.sv
// Serial-to-parallel capture of every input line.
module tsi_rx_capture #(
    parameter int IN_LINES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [IN_LINES-1:0]                    pcm_in,
    output tsi_pkg::pcm_byte_t [IN_LINES-1:0]      rx_bytes
);
    typedef struct packed {
        logic [IN_LINES-1:0][6:0] sh;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        for (int i = 0; i < IN_LINES; i++) begin
            rx_bytes[i] = {rx_q.sh[i], pcm_in[i]};
            rx_d.sh[i]  = {rx_q.sh[i][5:0], pcm_in[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rx_q <= '0;
        else     rx_q <= rx_d;
    end

endmodule

// File: rtl/tsi_data_mem.sv
// One copy of the frame store: all lines written per slot, RD_PORTS async reads.
module tsi_data_mem #(
    parameter int IN_LINES = 4,
    parameter int SLOTS    = 4,
    parameter int RD_PORTS = 2
) (
    input  logic                                         clk,
    input  logic                                         we,
    input  logic [$clog2(SLOTS)-1:0]                     wslot,
    input  tsi_pkg::pcm_byte_t [IN_LINES-1:0]            wbytes,
    input  logic [RD_PORTS-1:0][$clog2(IN_LINES*SLOTS)-1:0] raddr,
    output tsi_pkg::pcm_byte_t [RD_PORTS-1:0]            rdata
);
    localparam int CH = IN_LINES * SLOTS;
    localparam int AW = $clog2(CH);

    tsi_pkg::pcm_byte_t mem_d [CH];
    tsi_pkg::pcm_byte_t mem_q [CH];
    logic [AW-1:0]      waddr;

    always_comb begin
        mem_d = mem_q;
        waddr = '0;
        for (int i = 0; i < IN_LINES; i++) begin
            waddr = AW'(i * SLOTS) + AW'(wslot);
            if (we) mem_d[waddr] = wbytes[i];
        end
        for (int r = 0; r < RD_PORTS; r++) begin
            rdata[r] = mem_q[raddr[r]];
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/tsi_conn_bank.sv
// Connection entries for one half of the output lines plus their serializers.
module tsi_conn_bank #(
    parameter int LINES = 2,
    parameter int SLOTS = 4,
    parameter int AW    = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 host_we,
    input  logic [$clog2(LINES*SLOTS)-1:0]       host_idx,
    input  logic [AW-1:0]                        host_src,
    input  logic                                 host_hiz,
    input  logic                                 clr_we,
    input  logic [$clog2(LINES*SLOTS)-1:0]       clr_idx,
    input  logic                                 load,
    input  logic [$clog2(SLOTS)-1:0]             next_slot,
    output logic [LINES-1:0][AW-1:0]             dm_raddr,
    input  tsi_pkg::pcm_byte_t [LINES-1:0]       dm_rdata,
    input  logic [LINES-1:0]                     line_en,
    output logic [LINES-1:0]                     pcm_out,
    output logic [LINES-1:0]                     pcm_oe
);
    localparam int ENTRIES = LINES * SLOTS;
    localparam int EW      = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]                 hiz;
        tsi_pkg::pcm_byte_t [LINES-1:0]     sh;
        logic [LINES-1:0]                   slot_en;
    } bank_t;

    bank_t         bk_d, bk_q;
    logic [AW-1:0] src_d [ENTRIES];
    logic [AW-1:0] src_q [ENTRIES];
    logic [EW-1:0] rd_idx [LINES];

    always_comb begin
        bk_d  = bk_q;
        src_d = src_q;

        // serializer: load the upcoming slot on the last bit, shift otherwise
        for (int l = 0; l < LINES; l++) begin
            rd_idx[l]   = EW'(l * SLOTS) + EW'(next_slot);
            dm_raddr[l] = src_q[rd_idx[l]];
            if (load) begin
                bk_d.sh[l]      = dm_rdata[l];
                bk_d.slot_en[l] = !bk_q.hiz[rd_idx[l]];
            end else begin
                bk_d.sh[l]      = {bk_q.sh[l][6:0], 1'b0};
            end
        end

        // entry update: the clear walk wins over host writes
        if (clr_we) begin
            bk_d.hiz[clr_idx] = 1'b1;
        end else if (host_we) begin
            bk_d.hiz[host_idx] = host_hiz;
            src_d[host_idx]    = host_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_q.hiz     <= '1;
            bk_q.sh      <= '0;
            bk_q.slot_en <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    always_ff @(posedge clk) begin
        src_q <= src_d;
    end

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            assign pcm_oe[l]  = bk_q.slot_en[l] & line_en[l];
            assign pcm_out[l] = bk_q.sh[l][7] & pcm_oe[l];
        end
    endgenerate

endmodule

// File: rtl/tsi_clr_walk.sv
// Walks every entry index once, one per clock, then pulses done.
module tsi_clr_walk #(
    parameter int ENTRIES = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         walk_we,
    output logic [$clog2(ENTRIES)-1:0]   walk_idx
);
    localparam int EW = $clog2(ENTRIES);

    typedef struct packed {
        tsi_pkg::walk_state_e st;
        logic [EW-1:0]        idx;
        logic                 done;
    } walk_t;

    walk_t wk_d, wk_q;

    always_comb begin
        wk_d      = wk_q;
        wk_d.done = 1'b0;
        unique case (wk_q.st)
            tsi_pkg::WALK_IDLE: begin
                if (start) begin
                    wk_d.st  = tsi_pkg::WALK_RUN;
                    wk_d.idx = '0;
                end
            end
            tsi_pkg::WALK_RUN: begin
                if (wk_q.idx == EW'(ENTRIES - 1)) begin
                    wk_d.st   = tsi_pkg::WALK_IDLE;
                    wk_d.done = 1'b1;
                end else begin
                    wk_d.idx = wk_q.idx + EW'(1);
                end
            end
            default: wk_d.st = tsi_pkg::WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_q.st   <= tsi_pkg::WALK_IDLE;
            wk_q.idx  <= '0;
            wk_q.done <= 1'b0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy     = (wk_q.st == tsi_pkg::WALK_RUN);
    assign walk_we  = busy;
    assign walk_idx = wk_q.idx;
    assign done     = wk_q.done;

endmodule

// File: rtl/tsi_core.sv
module tsi_core #(
    parameter int IN_LINES  = 4,
    parameter int OUT_LINES = 4,
    parameter int SLOTS     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  fsync,
    input  logic [IN_LINES-1:0]                   pcm_in,
    input  logic [OUT_LINES-1:0]                  line_en,
    input  logic                                  cm_we,
    input  logic [$clog2(OUT_LINES*SLOTS)-1:0]    cm_addr,
    input  logic [$clog2(IN_LINES*SLOTS)-1:0]     cm_src,
    input  logic                                  cm_hiz,
    input  logic                                  clr_start,
    output logic [OUT_LINES-1:0]                  pcm_out,
    output logic [OUT_LINES-1:0]                  pcm_oe,
    output logic                                  clr_busy,
    output logic                                  clr_done
);
    localparam int SW       = $clog2(SLOTS);
    localparam int AW       = $clog2(IN_LINES * SLOTS);
    localparam int HALF     = OUT_LINES / 2;
    localparam int BANK_ENT = HALF * SLOTS;
    localparam int EW       = $clog2(BANK_ENT);
    localparam int OAW      = EW + 1;

    logic [SW-1:0]                  slot, next_slot;
    logic                           bit_last;
    tsi_pkg::pcm_byte_t [IN_LINES-1:0] rx_bytes;
    logic                           walk_we;
    logic [EW-1:0]                  walk_idx;
    logic                           host_ok;

    tsi_frame_timer #(.SLOTS(SLOTS)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .fsync     (fsync),
        .slot      (slot),
        .next_slot (next_slot),
        .bit_last  (bit_last)
    );

    tsi_rx_capture #(.IN_LINES(IN_LINES)) i_rx (
        .clk      (clk),
        .rst      (rst),
        .pcm_in   (pcm_in),
        .rx_bytes (rx_bytes)
    );

    tsi_clr_walk #(.ENTRIES(BANK_ENT)) i_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (clr_start),
        .busy     (clr_busy),
        .done     (clr_done),
        .walk_we  (walk_we),
        .walk_idx (walk_idx)
    );

    // host writes are dropped while the walk runs
    assign host_ok = cm_we && !clr_busy;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_half
            logic [HALF-1:0][AW-1:0]          rd_addr;
            tsi_pkg::pcm_byte_t [HALF-1:0]    rd_data;
            logic                             sel;

            assign sel = host_ok && (cm_addr[OAW-1] == 1'(b));

            tsi_data_mem #(
                .IN_LINES (IN_LINES),
                .SLOTS    (SLOTS),
                .RD_PORTS (HALF)
            ) i_dm (
                .clk    (clk),
                .we     (bit_last),
                .wslot  (slot),
                .wbytes (rx_bytes),
                .raddr  (rd_addr),
                .rdata  (rd_data)
            );

            tsi_conn_bank #(
                .LINES (HALF),
                .SLOTS (SLOTS),
                .AW    (AW)
            ) i_bank (
                .clk       (clk),
                .rst       (rst),
                .host_we   (sel),
                .host_idx  (cm_addr[EW-1:0]),
                .host_src  (cm_src),
                .host_hiz  (cm_hiz),
                .clr_we    (walk_we),
                .clr_idx   (walk_idx),
                .load      (bit_last),
                .next_slot (next_slot),
                .dm_raddr  (rd_addr),
                .dm_rdata  (rd_data),
                .line_en   (line_en[b*HALF +: HALF]),
                .pcm_out   (pcm_out[b*HALF +: HALF]),
                .pcm_oe    (pcm_oe[b*HALF +: HALF])
            );
        end
    endgenerate

endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
    parameter int OUT_LINES = 4,
    parameter int SLOTS     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [OUT_LINES-1:0] line_en,
    input logic [OUT_LINES-1:0] pcm_out,
    input logic [OUT_LINES-1:0] pcm_oe,
    input logic                 clr_start,
    input logic                 clr_busy,
    input logic                 clr_done
);
    localparam int WALK_LEN = (OUT_LINES / 2) * SLOTS;

    int unsigned busy_run_q;

    always_ff @(posedge clk) begin
        if (rst)           busy_run_q <= 0;
        else if (clr_busy) busy_run_q <= busy_run_q + 1;
        else               busy_run_q <= 0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!clr_busy && !clr_done && pcm_oe == '0));

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_start && !clr_busy) |=> clr_busy);

    // R7
    walk_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_busy) |-> (busy_run_q == 32'(WALK_LEN)));

    // R7
    done_after_walk_chk: assert property (@(posedge clk) disable iff (rst)
        clr_done |-> (!clr_busy && $past(clr_busy)));

    // R4
    silent_data_chk: assert property (@(posedge clk) disable iff (rst)
        (pcm_out & ~pcm_oe) == '0);

    // R5
    line_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (pcm_oe & ~line_en) == '0);

endmodule

bind tsi_core tsi_core_chk #(
    .OUT_LINES (OUT_LINES),
    .SLOTS     (SLOTS)
) i_tsi_core_chk (
    .clk       (clk),
    .rst       (rst),
    .line_en   (line_en),
    .pcm_out   (pcm_out),
    .pcm_oe    (pcm_oe),
    .clr_start (clr_start),
    .clr_busy  (clr_busy),
    .clr_done  (clr_done)
);

// File: tb/test_tsi_core.sv
`timescale 1ns/1ps
module test_tsi_core;
    localparam int IL = 4;
    localparam int OL = 4;
    localparam int SL = 4;
    localparam int CH = IL * SL;
    localparam int OE = OL * SL;
    localparam int FB = SL * 8;
    localparam int BE = (OL / 2) * SL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fsync = 1'b0;
    logic [IL-1:0] pcm_in = '0;
    logic [OL-1:0] line_en = '1;
    logic          cm_we = 1'b0;
    logic [3:0]    cm_addr = '0;
    logic [3:0]    cm_src = '0;
    logic          cm_hiz = 1'b0;
    logic          clr_start = 1'b0;
    logic [OL-1:0] pcm_out, pcm_oe;
    logic          clr_busy, clr_done;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;

    logic [7:0] in_data [IL][SL];
    int         m_src [OE];
    bit         m_hiz [OE];

    always #2 clk = ~clk;

    tsi_core #(.IN_LINES(IL), .OUT_LINES(OL), .SLOTS(SL)) i_tsi_core (
        .clk(clk), .rst(rst), .fsync(fsync), .pcm_in(pcm_in), .line_en(line_en),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src), .cm_hiz(cm_hiz),
        .clr_start(clr_start), .pcm_out(pcm_out), .pcm_oe(pcm_oe),
        .clr_busy(clr_busy), .clr_done(clr_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic step();
        for (int i = 0; i < IL; i++) pcm_in[i] = in_data[i][pos / 8][7 - (pos % 8)];
        @(posedge clk);
        #1;
        pos = (pos + 1) % FB;
    endtask

    task automatic cm_wr(input int a, input int s, input bit h);
        cm_addr = 4'(a); cm_src = 4'(s); cm_hiz = h; cm_we = 1'b1;
        step();
        cm_we = 1'b0;
        m_src[a] = s; m_hiz[a] = h;
    endtask

    task automatic load_data(input int seed);
        for (int i = 0; i < IL; i++)
            for (int j = 0; j < SL; j++)
                in_data[i][j] = 8'((i * 37 + j * 91 + seed * 29 + 5) ^ (seed * 13));
    endtask

    task automatic do_sync();
        fsync = 1'b1;
        pos = 0;
        step();
        fsync = 1'b0;
    endtask

    // warm frame, then compare a full frame on every line
    task automatic check_frame(input string req);
        logic [FB-1:0] obs_o [OL];
        logic [FB-1:0] obs_e [OL];
        logic [FB-1:0] exp_o [OL];
        logic [FB-1:0] exp_e [OL];
        while (pos != 0) step();
        repeat (FB) step();
        for (int p = 0; p < FB; p++) begin
            for (int k = 0; k < OL; k++) begin
                int e, src;
                e = k * SL + p / 8;
                src = m_src[e];
                obs_o[k][p] = pcm_out[k];
                obs_e[k][p] = pcm_oe[k];
                if (m_hiz[e] || !line_en[k]) begin
                    exp_o[k][p] = 1'b0; exp_e[k][p] = 1'b0;
                end else begin
                    exp_e[k][p] = 1'b1;
                    exp_o[k][p] = in_data[src / SL][src % SL][7 - (p % 8)];
                end
            end
            step();
        end
        for (int k = 0; k < OL; k++) begin
            chk(obs_o[k] == exp_o[k], req, longint'(obs_o[k]), longint'(exp_o[k]));
            chk(obs_e[k] == exp_e[k], req, longint'(obs_e[k]), longint'(exp_e[k]));
        end
    endtask

    // mode 0: plain walk, 1: host writes during walk, 2: second start during walk
    task automatic clear_run(input int mode, input string req);
        int n;
        clr_start = 1'b1;
        step();
        clr_start = 1'b0;
        chk(clr_busy == 1'b1, req, clr_busy, 1);
        n = 0;
        while (clr_busy && n < 100) begin
            if (mode == 1 && n == 3) begin cm_addr = 4'd0; cm_src = 4'd5; cm_hiz = 1'b0; cm_we = 1'b1; end
            if (mode == 1 && n == 4) begin cm_addr = 4'd8; cm_src = 4'd9; cm_hiz = 1'b0; cm_we = 1'b1; end
            if (mode == 2 && n == 3) clr_start = 1'b1;
            step();
            cm_we = 1'b0;
            clr_start = 1'b0;
            n++;
        end
        chk(n == BE, req, n, BE);
        chk(clr_done == 1'b1, req, clr_done, 1);
        step();
        chk(clr_done == 1'b0, req, clr_done, 0);
        for (int e = 0; e < OE; e++) m_hiz[e] = 1'b1;
    endtask

    task automatic map_all(input int mul, input int add);
        for (int e = 0; e < OE; e++) cm_wr(e, (e * mul + add) % CH, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        chk(clr_busy == 1'b0, "R1 busy", clr_busy, 0);
        chk(clr_done == 1'b0, "R1 done", clr_done, 0);
        chk(pcm_oe == '0, "R1 oe", pcm_oe, 0);
        do_sync();
        check_frame("R1 entries tristate");
    endtask

    task automatic t_switch();
        load_data(1);
        map_all(5, 3);
        check_frame("R2 mapping A");
        load_data(2);
        map_all(7, 1);
        check_frame("R2 mapping B");
    endtask

    task automatic t_halves();
        load_data(3);
        for (int e = 0; e < BE; e++) begin
            cm_wr(e, (e * 3) % CH, 1'b0);
            cm_wr(e + BE, (e * 3) % CH, 1'b0);
        end
        check_frame("R3 shared source");
    endtask

    task automatic t_hiz();
        load_data(4);
        for (int e = 0; e < OE; e++) cm_wr(e, (e * 11 + 2) % CH, (e % 3) == 0);
        check_frame("R4 slot tristate");
    endtask

    task automatic t_mask();
        line_en = 4'b0101;
        check_frame("R5 line mask");
        line_en = 4'b1010;
        check_frame("R5 line mask alt");
        line_en = '1;
    endtask

    task automatic t_resync();
        load_data(5);
        map_all(1, 0);
        repeat (13) step();
        do_sync();
        check_frame("R6 resync");
        fsync = 1'b1;
        step();
        repeat (20) step();
        fsync = 1'b0;
        pos = (pos + FB - 21) % FB;
        step();
        pos = (pos + 21) % FB;
        check_frame("R6 held sync");
    endtask

    task automatic t_clear();
        map_all(3, 1);
        clear_run(0, "R7 walk");
        check_frame("R7 all tristate");
        map_all(5, 2);
        clear_run(1, "R8 walk");
        check_frame("R8 writes ignored");
        map_all(5, 2);
        clear_run(2, "R9 restart ignored");
        check_frame("R9 all tristate");
    endtask

    initial begin
        for (int e = 0; e < OE; e++) begin m_src[e] = 0; m_hiz[e] = 1'b1; end
        load_data(0);
        t_reset();
        t_switch();
        t_halves();
        t_hiz();
        t_mask();
        t_clear();
        t_resync();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule